// File: doc/BRIEF.md
# Machine-Mode Trap Entry Unit

This block sits beside the execute stage of an in-order core. For every executing instruction it sees the program counter, the raw 32-bit instruction word, the decoder's illegal-instruction flag, and (for memory operations) the access direction, size, base register value and 12-bit immediate. It forms the effective address and checks it against the natural alignment of the access size. It then decides in the same cycle whether the instruction traps and drives the next program counter.

On a trap, the next PC is the machine trap vector. On the following clock edge the unit records the faulting PC, a cause code, and either the offending instruction word or the faulting address. A supervisor-return request, honoured even in machine mode, steers the next PC to the saved supervisor exception PC. A faulting memory access has its memory and write-back enable withheld. Two software-writable registers, the trap vector and the supervisor exception PC, are loaded through a small write port.

The `XLEN` parameter selects a 64-bit build, in which doubleword accesses are alignment-checked, or a 32-bit build, in which a doubleword access is an illegal instruction.

Top module: `mtrap_entry`

## Requirements
- R1: The effective address is base plus the sign-extended 12-bit offset. Size encoding: 0 byte, 1 half, 2 word, 3 double. A half access faults when address bit 0 is set, a word access when bits 1:0 are nonzero, and a double access (XLEN=64) when bits 2:0 are nonzero. A byte access never faults, and with `mem_en_i` low no alignment fault is raised.
- R2: A misaligned access with `mem_store_i`=0 writes cause 4, and one with `mem_store_i`=1 writes cause 6. In both cases the trap value register receives the effective address.
- R3: `illegal_i` high raises cause 2 and loads the trap value register with the 32-bit instruction word, zero-extended. Illegal has priority over misalignment and over supervisor return.
- R4: With XLEN=32, a double access is treated as illegal: cause 2, with the instruction word as trap value.
- R5: On any trap, `trap_o` is high, `next_pc_o` equals the current trap vector in the same cycle, and at the next edge the exception PC register holds `pc_i`.
- R6: Reset (active-low, asynchronous) sets the trap vector to 0x1010 and clears the exception PC, cause, trap value and supervisor exception PC registers.
- R7: A valid instruction that neither traps nor returns gives `next_pc_o` = `pc_i` + 4.
- R8: `sret_i` on a valid instruction that does not trap gives `next_pc_o` equal to the supervisor exception PC.
- R9: `access_ok_o` is high only for a valid, non-trapping instruction with `mem_en_i` high, so a faulting access performs no memory write or write-back.
- R10: When no trap is taken, including when `valid_i` is low, the exception PC, cause and trap value registers keep their values. Writes with `csr_sel_i`=0 load the trap vector with bits 1:0 cleared, and writes with `csr_sel_i`=1 load the supervisor exception PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction executes this cycle |
| pc_i | input | XLEN | PC of the executing instruction |
| instr_i | input | 32 | Raw instruction word |
| illegal_i | input | 1 | Decoder flags the instruction illegal |
| sret_i | input | 1 | Instruction is a supervisor return |
| mem_en_i | input | 1 | Instruction is a load or store |
| mem_store_i | input | 1 | 1 = store, 0 = load |
| mem_size_i | input | 2 | Access size code |
| base_i | input | XLEN | Base register value |
| offset_i | input | 12 | Signed address offset |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 1 | 0 = trap vector, 1 = supervisor exception PC |
| csr_wdata_i | input | XLEN | Register write data |
| trap_o | output | 1 | Trap taken this cycle |
| access_ok_o | output | 1 | Memory access and write-back may proceed |
| next_pc_o | output | XLEN | Next program counter |
| mtvec_o | output | XLEN | Trap vector |
| mepc_o | output | XLEN | Exception PC |
| mcause_o | output | XLEN | Trap cause |
| mtval_o | output | XLEN | Trap value |
| sepc_o | output | XLEN | Supervisor exception PC |

## Verification
The assertions assume that every control input is a known value at each clock edge once reset is released. They also assume that `illegal_i`, `sret_i` and the memory fields describe a single instruction only while `valid_i` is high. The checks on the next PC and on `access_ok_o` are qualified by `valid_i`, because those outputs carry no meaning otherwise. The bench drives all inputs on the falling edge, holds them for a whole cycle, and returns `valid_i` low between instructions. This keeps every sampled cycle describing at most one instruction with stable operands.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int OFF_W   = 12;
  localparam int ILEN    = 32;
  localparam int CODE_W  = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic {
    SEL_TVEC = 1'b0,
    SEL_SEPC = 1'b1
  } csr_sel_e;

  localparam logic [CODE_W-1:0] CODE_ILLEGAL   = 4'd2;
  localparam logic [CODE_W-1:0] CODE_LD_ALIGN  = 4'd4;
  localparam logic [CODE_W-1:0] CODE_ST_ALIGN  = 4'd6;

  typedef struct packed {
    logic              take;
    logic [CODE_W-1:0] code;
    logic              tval_addr;
  } trap_info_t;
endpackage

// File: rtl/mtrap_addr_check.sv
module mtrap_addr_check
  import mtrap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [1:0]       size_i,
  output logic [XLEN-1:0]  ea_o,
  output logic             misaligned_o,
  output logic             size_illegal_o
);
  localparam int EXT_W = XLEN - OFF_W;

  logic dw_mis;
  logic dw_bad;

  assign ea_o = base_i + {{EXT_W{offset_i[OFF_W-1]}}, offset_i};

  generate
    if (XLEN >= 64) begin : g_dword
      assign dw_mis = |ea_o[2:0];
      assign dw_bad = 1'b0;
    end else begin : g_no_dword
      assign dw_mis = 1'b0;
      assign dw_bad = 1'b1;
    end
  endgenerate

  always_comb begin
    misaligned_o   = 1'b0;
    size_illegal_o = 1'b0;
    case (acc_size_e'(size_i))
      SZ_BYTE:  misaligned_o = 1'b0;
      SZ_HALF:  misaligned_o = ea_o[0];
      SZ_WORD:  misaligned_o = |ea_o[1:0];
      SZ_DWORD: begin
        misaligned_o   = dw_mis;
        size_illegal_o = dw_bad;
      end
      default:  misaligned_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mtrap_cause_sel.sv
module mtrap_cause_sel
  import mtrap_pkg::*;
(
  input  logic       valid_i,
  input  logic       illegal_i,
  input  logic       mem_en_i,
  input  logic       store_i,
  input  logic       misaligned_i,
  input  logic       size_illegal_i,
  output trap_info_t info_o
);
  logic ill_any;
  logic mis_any;

  assign ill_any = illegal_i | (mem_en_i & size_illegal_i);
  assign mis_any = mem_en_i & misaligned_i;

  // illegal outranks misalignment
  always_comb begin
    info_o = '0;
    if (valid_i) begin
      if (ill_any) begin
        info_o.take      = 1'b1;
        info_o.code      = CODE_ILLEGAL;
        info_o.tval_addr = 1'b0;
      end else if (mis_any) begin
        info_o.take      = 1'b1;
        info_o.code      = store_i ? CODE_ST_ALIGN : CODE_LD_ALIGN;
        info_o.tval_addr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtrap_csr_file.sv
module mtrap_csr_file
  import mtrap_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] TVEC_RST  = XLEN'(32'h1010)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   tval_i,
  input  logic [XLEN-1:0]   epc_i,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   mtvec_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mtval_o,
  output logic [XLEN-1:0]   sepc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mepc_o   <= '0;
      mcause_o <= '0;
      mtval_o  <= '0;
    end else if (trap_i) begin
      mepc_o   <= epc_i;
      mcause_o <= XLEN'(code_i);
      mtval_o  <= tval_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mtvec_o <= TVEC_RST;
      sepc_o  <= '0;
    end else if (we_i) begin
      if (csr_sel_e'(sel_i) == SEL_TVEC) mtvec_o <= {wdata_i[XLEN-1:2], 2'b00};
      else                               sepc_o  <= wdata_i;
    end
  end
endmodule

// File: rtl/mtrap_entry.sv
module mtrap_entry
  import mtrap_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] TVEC_RST = XLEN'(32'h1010)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [31:0]      instr_i,
  input  logic             illegal_i,
  input  logic             sret_i,
  input  logic             mem_en_i,
  input  logic             mem_store_i,
  input  logic [1:0]       mem_size_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [11:0]      offset_i,
  input  logic             csr_we_i,
  input  logic             csr_sel_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic             trap_o,
  output logic             access_ok_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [XLEN-1:0]  mtvec_o,
  output logic [XLEN-1:0]  mepc_o,
  output logic [XLEN-1:0]  mcause_o,
  output logic [XLEN-1:0]  mtval_o,
  output logic [XLEN-1:0]  sepc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);

  logic [XLEN-1:0] ea;
  logic            misaligned;
  logic            size_illegal;
  trap_info_t      info;
  logic [XLEN-1:0] tval;

  mtrap_addr_check #(.XLEN(XLEN)) i_addr (
    .base_i         (base_i),
    .offset_i       (offset_i),
    .size_i         (mem_size_i),
    .ea_o           (ea),
    .misaligned_o   (misaligned),
    .size_illegal_o (size_illegal)
  );

  mtrap_cause_sel i_cause (
    .valid_i        (valid_i),
    .illegal_i      (illegal_i),
    .mem_en_i       (mem_en_i),
    .store_i        (mem_store_i),
    .misaligned_i   (misaligned),
    .size_illegal_i (size_illegal),
    .info_o         (info)
  );

  assign tval = info.tval_addr ? ea : XLEN'(instr_i);

  mtrap_csr_file #(.XLEN(XLEN), .TVEC_RST(TVEC_RST)) i_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trap_i   (info.take),
    .code_i   (info.code),
    .tval_i   (tval),
    .epc_i    (pc_i),
    .we_i     (csr_we_i),
    .sel_i    (csr_sel_i),
    .wdata_i  (csr_wdata_i),
    .mtvec_o  (mtvec_o),
    .mepc_o   (mepc_o),
    .mcause_o (mcause_o),
    .mtval_o  (mtval_o),
    .sepc_o   (sepc_o)
  );

  assign trap_o      = info.take;
  assign access_ok_o = valid_i & mem_en_i & ~info.take;

  always_comb begin
    if (info.take)               next_pc_o = mtvec_o;
    else if (valid_i && sret_i)  next_pc_o = sepc_o;
    else                         next_pc_o = pc_i + STEP;
  end
endmodule

// File: rtl/mtrap_checker.sv
module mtrap_checker #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [XLEN-1:0] pc_i,
  input logic [31:0]     instr_i,
  input logic            illegal_i,
  input logic            sret_i,
  input logic            mem_en_i,
  input logic [1:0]      mem_size_i,
  input logic            trap_o,
  input logic            access_ok_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic [XLEN-1:0] mtvec_o,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] mcause_o,
  input logic [XLEN-1:0] mtval_o,
  input logic [XLEN-1:0] sepc_o
);
  AST_BYTE_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mem_en_i && mem_size_i == 2'd0 && !illegal_i |-> !trap_o); // R1
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && illegal_i |=> mcause_o == XLEN'(2) && mtval_o[31:0] == $past(instr_i)); // R3
  AST_TRAP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> next_pc_o == mtvec_o); // R5
  AST_EPC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> mepc_o == $past(pc_i)); // R5
  AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !trap_o && !sret_i |-> next_pc_o == pc_i + XLEN'(4)); // R7
  AST_SRET_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sret_i && !trap_o |-> next_pc_o == sepc_o); // R8
  AST_NO_ACCESS_ON_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !access_ok_o); // R9
  AST_HOLD_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |=> $stable(mepc_o) && $stable(mcause_o) && $stable(mtval_o)); // R10
  AST_IDLE_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !trap_o && !access_ok_o); // R10
endmodule

bind mtrap_entry mtrap_checker #(.XLEN(XLEN)) i_mtrap_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .pc_i        (pc_i),
  .instr_i     (instr_i),
  .illegal_i   (illegal_i),
  .sret_i      (sret_i),
  .mem_en_i    (mem_en_i),
  .mem_size_i  (mem_size_i),
  .trap_o      (trap_o),
  .access_ok_o (access_ok_o),
  .next_pc_o   (next_pc_o),
  .mtvec_o     (mtvec_o),
  .mepc_o      (mepc_o),
  .mcause_o    (mcause_o),
  .mtval_o     (mtval_o),
  .sepc_o      (sepc_o)
);

// File: tb/test_mtrap_entry.sv
module test_mtrap_entry;
  localparam time PERIOD = 10ns;
  localparam int  NV     = 17;

  typedef struct packed {
    logic        ill;
    logic        mem;
    logic        st;
    logic [1:0]  sz;
    logic [63:0] base;
    logic [11:0] off;
    logic [31:0] ins;
    logic        trap;
    logic [3:0]  cause;
    logic [63:0] tval;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 2'd0, 64'h0,   12'h005, 32'h00558503, 1'b0, 4'd0, 64'h0},
    '{1'b0, 1'b1, 1'b0, 2'd1, 64'h1,   12'h005, 32'h00559503, 1'b0, 4'd0, 64'h0},
    '{1'b0, 1'b1, 1'b0, 2'd1, 64'h0,   12'h005, 32'h00559503, 1'b1, 4'd4, 64'h5},
    '{1'b0, 1'b1, 1'b0, 2'd2, 64'h3,   12'h005, 32'h0055a503, 1'b0, 4'd0, 64'h0},
    '{1'b0, 1'b1, 1'b0, 2'd2, 64'h0,   12'h005, 32'h0055a503, 1'b1, 4'd4, 64'h5},
    '{1'b0, 1'b1, 1'b0, 2'd3, 64'h3,   12'h005, 32'h0055b503, 1'b0, 4'd0, 64'h0},
    '{1'b0, 1'b1, 1'b0, 2'd3, 64'h10,  12'hffc, 32'h0055b503, 1'b1, 4'd4, 64'hc},
    '{1'b0, 1'b1, 1'b1, 2'd0, 64'h0,   12'h005, 32'h00a582a3, 1'b0, 4'd0, 64'h0},
    '{1'b0, 1'b1, 1'b1, 2'd1, 64'h0,   12'h005, 32'h00a592a3, 1'b1, 4'd6, 64'h5},
    '{1'b0, 1'b1, 1'b1, 2'd2, 64'h1,   12'h005, 32'h00a5a2a3, 1'b1, 4'd6, 64'h6},
    '{1'b0, 1'b1, 1'b1, 2'd3, 64'h1,   12'h005, 32'h00a5b2a3, 1'b1, 4'd6, 64'h6},
    '{1'b0, 1'b1, 1'b1, 2'd3, 64'h3,   12'h005, 32'h00a5b2a3, 1'b0, 4'd0, 64'h0},
    '{1'b1, 1'b1, 1'b1, 2'd1, 64'h0,   12'h005, 32'h00008000, 1'b1, 4'd2, 64'h8000},
    '{1'b1, 1'b0, 1'b0, 2'd0, 64'h0,   12'h000, 32'hf120d073, 1'b1, 4'd2, 64'hf120d073},
    '{1'b0, 1'b1, 1'b0, 2'd2, 64'h100, 12'hfff, 32'h0055a503, 1'b1, 4'd4, 64'hff},
    '{1'b0, 1'b0, 1'b0, 2'd1, 64'h0,   12'h005, 32'h00559503, 1'b0, 4'd0, 64'h0},
    '{1'b0, 1'b1, 1'b1, 2'd0, 64'h7,   12'h000, 32'h00a582a3, 1'b0, 4'd0, 64'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, ill = 1'b0, sret = 1'b0, mem_en = 1'b0, store = 1'b0;
  logic [1:0]  size = '0;
  logic [63:0] pc = '0, base = '0, csr_wd = '0;
  logic [31:0] instr = '0;
  logic [11:0] off = '0;
  logic csr_we = 1'b0, csr_sel = 1'b0;

  logic trap, ok;
  logic [63:0] npc, mtvec, mepc, mcause, mtval, sepc;
  logic trap32, ok32;
  logic [31:0] npc32, mtvec32, mepc32, mcause32, mtval32, sepc32;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [63:0] e_mepc = '0, e_mcause = '0, e_mtval = '0;

  always #(PERIOD/2) clk = ~clk;

  mtrap_entry #(.XLEN(64)) i_mtrap_entry (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pc_i(pc), .instr_i(instr),
    .illegal_i(ill), .sret_i(sret), .mem_en_i(mem_en), .mem_store_i(store),
    .mem_size_i(size), .base_i(base), .offset_i(off), .csr_we_i(csr_we),
    .csr_sel_i(csr_sel), .csr_wdata_i(csr_wd), .trap_o(trap), .access_ok_o(ok),
    .next_pc_o(npc), .mtvec_o(mtvec), .mepc_o(mepc), .mcause_o(mcause),
    .mtval_o(mtval), .sepc_o(sepc)
  );

  mtrap_entry #(.XLEN(32)) i_mtrap_entry_rv32 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pc_i(pc[31:0]), .instr_i(instr),
    .illegal_i(ill), .sret_i(sret), .mem_en_i(mem_en), .mem_store_i(store),
    .mem_size_i(size), .base_i(base[31:0]), .offset_i(off), .csr_we_i(csr_we),
    .csr_sel_i(csr_sel), .csr_wdata_i(csr_wd[31:0]), .trap_o(trap32), .access_ok_o(ok32),
    .next_pc_o(npc32), .mtvec_o(mtvec32), .mepc_o(mepc32), .mcause_o(mcause32),
    .mtval_o(mtval32), .sepc_o(sepc32)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic idle();
    valid = 1'b0; ill = 1'b0; sret = 1'b0; mem_en = 1'b0; csr_we = 1'b0;
  endtask

  task automatic regs_hold(input string tag);
    chk(tag, mepc, e_mepc);
    chk(tag, mcause, e_mcause);
    chk(tag, mtval, e_mtval);
  endtask

  initial begin
    #(PERIOD * 20000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R6 reset state
    chk("R6 mtvec", mtvec, 64'h1010);
    chk("R6 mepc", mepc, 0);
    chk("R6 mcause", mcause, 0);
    chk("R6 mtval", mtval, 0);
    chk("R6 sepc", sepc, 0);
    chk("R6 trap idle", {63'b0, trap}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      @(negedge clk);
      valid = 1'b1; ill = VECS[i].ill; mem_en = VECS[i].mem; store = VECS[i].st;
      size = VECS[i].sz; base = VECS[i].base; off = VECS[i].off; instr = VECS[i].ins;
      pc = 64'h2000 + 64'(4 * i);
      tag = !VECS[i].trap ? "R1" : (VECS[i].cause == 4'd2 ? "R3" : "R2");
      #1;
      chk({tag, " trap"}, {63'b0, trap}, {63'b0, VECS[i].trap});
      chk(VECS[i].trap ? "R5 next_pc" : "R7 next_pc", npc,
          VECS[i].trap ? 64'h1010 : pc + 64'd4);
      chk("R9 access_ok", {63'b0, ok}, {63'b0, VECS[i].mem & ~VECS[i].trap});
      if (VECS[i].trap) begin
        e_mepc = pc; e_mcause = {60'b0, VECS[i].cause}; e_mtval = VECS[i].tval;
      end
      @(posedge clk); #1;
      regs_hold(VECS[i].trap ? {tag, " R5 regs"} : "R10 hold");
      idle();
    end

    // R4: double access in 32-bit build is illegal; fine in 64-bit build
    @(negedge clk);
    valid = 1'b1; mem_en = 1'b1; store = 1'b0; size = 2'd3; base = 64'h3; off = 12'h005;
    instr = 32'h0055b503; pc = 64'h3000;
    #1;
    chk("R1 dword ok 64", {63'b0, trap}, 0);
    chk("R7 next_pc 64", npc, 64'h3004);
    chk("R4 trap rv32", {63'b0, trap32}, 1);
    chk("R5 next_pc rv32", {32'b0, npc32}, 64'h1010);
    @(posedge clk); #1;
    chk("R4 mcause rv32", {32'b0, mcause32}, 2);
    chk("R4 mtval rv32", {32'b0, mtval32}, 64'h0055b503);
    chk("R5 mepc rv32", {32'b0, mepc32}, 64'h3000);
    regs_hold("R10 hold after dword");

    // R1/R2 word misalign on both builds
    @(negedge clk);
    size = 2'd2; base = 64'h0; instr = 32'h0055a503; pc = 64'h3004;
    e_mepc = pc; e_mcause = 4; e_mtval = 5;
    @(posedge clk); #1;
    regs_hold("R2 word load 64");
    chk("R2 mcause rv32", {32'b0, mcause32}, 4);
    chk("R2 mtval rv32", {32'b0, mtval32}, 5);
    idle();

    // R10: register writes while idle; illegal without valid is ignored
    @(negedge clk);
    ill = 1'b1; csr_we = 1'b1; csr_sel = 1'b1; csr_wd = 64'h1234;
    #1;
    chk("R10 no trap when idle", {63'b0, trap}, 0);
    @(negedge clk);
    csr_sel = 1'b0; csr_wd = 64'h3003;
    @(negedge clk);
    idle();
    chk("R10 sepc write", sepc, 64'h1234);
    chk("R10 mtvec write", mtvec, 64'h3000);
    regs_hold("R10 hold idle illegal");

    // R8 sret
    @(negedge clk);
    valid = 1'b1; sret = 1'b1; pc = 64'h4004; instr = 32'h10200073;
    #1;
    chk("R8 sret next_pc", npc, 64'h1234);
    chk("R8 no trap", {63'b0, trap}, 0);
    // R3 illegal beats sret, trap goes to new vector
    @(negedge clk);
    ill = 1'b1; pc = 64'h4008; instr = 32'hfff0d073;
    #1;
    chk("R5 next_pc new vector", npc, 64'h3000);
    chk("R3 trap over sret", {63'b0, trap}, 1);
    @(posedge clk); #1;
    e_mepc = 64'h4008; e_mcause = 2; e_mtval = 64'hfff0d073;
    regs_hold("R3 illegal regs");
    idle();

    // R6 asynchronous reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R6 mtvec after reset", mtvec, 64'h1010);
    chk("R6 sepc after reset", sepc, 0);
    chk("R6 mcause after reset", mcause, 0);
    chk("R6 mepc after reset", mepc, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule